// File: doc/BRIEF.md
# Clock Controller Register Block

This block is the software-visible register file of a clock management unit. It sits on a simple 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. The block holds the clock-gating enables for the system clocks and for the peripherals. It also holds the configuration words for the oscillator, two PLLs, the master clock and four programmable clocks, together with a status word and an interrupt mask. It drives one level-sensitive interrupt.

The gating enables are never written directly. Each has a write-one-to-set address and a write-one-to-clear address, and a third address reads the current value back. No lock or settling time is modelled. Writing the oscillator word or a PLL word raises its stable or lock flag at once. The master-clock-ready flag follows an input driven by an external frequency calculator. A read-only frequency-measure word reports the oscillator frequency, which is a static input, in units of 16 slow-clock periods.

Top module: `clkctl_regs`

## Requirements
- R1: Read data is combinational from the address. Offsets: system clock status 0x08, peripheral clock status 0x18, oscillator word 0x20, PLL A word 0x28, PLL B word 0x2C, master clock word 0x30, programmable clock words 0x40/0x44/0x48/0x4C, status 0x68, interrupt mask 0x6C. Writing 0x20, 0x28, 0x2C, 0x30 or 0x40–0x4C stores the full 32-bit value, and the value reads back from the next cycle.
- R2: A write to 0x00 ORs bits 11:7 of the data into the system clock status, and a write to 0x04 clears the bits of 11:7 that are set in the data. All other status bits keep their value, including bit 0, which resets to 1.
- R3: A write to 0x10 ORs the data, with bits 1:0 forced to zero, into the peripheral clock status, and a write to 0x14 clears the same bits. Bits 1:0 always read 0.
- R4: Status bit 0 (oscillator stable) is set by any write to 0x20, bit 1 (PLL A lock) by any write to 0x28 and bit 2 (PLL B lock) by any write to 0x2C. Once set, these bits stay set until reset.
- R5: Status bit 3 (master clock ready) takes the value of mck_ready_i one cycle later. Status bits 31:4 read 0.
- R6: A write to 0x60 ORs the data into the interrupt mask, and a write to 0x64 clears the bits that are set in the data.
- R7: irq_o is registered. It equals the OR of (status AND mask) as those registers stood one cycle earlier, so it changes one cycle after the write that changes status or mask.
- R8: A read of 0x24 returns 0 when oscillator word bit 0 is 0. Otherwise it returns bit 16 set, ORed with osc_freq_i / 32768 / 16.
- R9: 0x00, 0x04, 0x10, 0x14, 0x60, 0x64 and every unmapped address read as 0. Writes to unmapped or read-only addresses change no register.
- R10: After reset: system clock status 0x1, peripheral status 0, oscillator 0, both PLL words 0x3F00, master clock 0, programmable clocks 0, status 0x8, mask 0, irq_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 7 | Byte address within the register window |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| osc_freq_i | input | 32 | Oscillator frequency in Hz, static |
| mck_ready_i | input | 1 | Master clock ready from the frequency calculator |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench goes after the masked set/clear paths. If the wrong field were masked, system status bit 0 would drop after a disable of all ones, or peripheral bits 1:0 would read 1. Sticky lock flags are driven by repeated writes while mck_ready_i toggles, and a design that cleared them would show a stale status. The interrupt latency is probed in the cycle just after a mask write, where a combinational irq would already be high. Random writes that also hit unmapped and read-only offsets are followed by a readback of every offset, so a decode alias corrupts some other word.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam logic [7:0] OFF_SYS_EN  = 8'h00;
  localparam logic [7:0] OFF_SYS_DIS = 8'h04;
  localparam logic [7:0] OFF_SYS_ST  = 8'h08;
  localparam logic [7:0] OFF_PER_EN  = 8'h10;
  localparam logic [7:0] OFF_PER_DIS = 8'h14;
  localparam logic [7:0] OFF_PER_ST  = 8'h18;
  localparam logic [7:0] OFF_OSC     = 8'h20;
  localparam logic [7:0] OFF_FMEAS   = 8'h24;
  localparam logic [7:0] OFF_PLL_A   = 8'h28;
  localparam logic [7:0] OFF_PLL_B   = 8'h2C;
  localparam logic [7:0] OFF_MCK     = 8'h30;
  localparam logic [7:0] OFF_PCK0    = 8'h40;
  localparam logic [7:0] OFF_IEN     = 8'h60;
  localparam logic [7:0] OFF_IDIS    = 8'h64;
  localparam logic [7:0] OFF_STAT    = 8'h68;
  localparam logic [7:0] OFF_MASK    = 8'h6C;

  localparam int unsigned NUM_FLAGS  = 4;
  localparam int unsigned FL_OSC     = 0;
  localparam int unsigned FL_LOCK_A  = 1;
  localparam int unsigned FL_LOCK_B  = 2;
  localparam int unsigned FL_MCK     = 3;

  localparam logic [31:0] SYS_MASK   = 32'h0000_0F80;
  localparam logic [31:0] PER_MASK   = 32'hFFFF_FFFC;
  localparam logic [31:0] SYS_RST    = 32'h0000_0001;
  localparam logic [31:0] PLL_RST    = 32'h0000_3F00;
  // log2(32768 * 16)
  localparam int unsigned FMEAS_SHIFT = 19;
  localparam int unsigned FMEAS_VALID = 16;
endpackage

// File: rtl/clkctl_setclr.sv
module clkctl_setclr #(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] MASK    = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sel;
  assign sel = wdata_i & MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (set_i) q_o <= q_o | sel;
    else if (clr_i) q_o <= q_o & ~sel;
  end

  AST_UNMASKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((q_o & ~MASK) == ($past(q_o) & ~MASK))) else $error("unmasked bit moved"); // R2
  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(sel)) == $past(sel))) else $error("set lost"); // R6
endmodule

// File: rtl/clkctl_cfg.sv
module clkctl_cfg #(
  parameter int unsigned NUM_PCK = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     osc_wr_i,
  input  logic                     pa_wr_i,
  input  logic                     pb_wr_i,
  input  logic                     mck_wr_i,
  input  logic [NUM_PCK-1:0]       pck_wr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              osc_o,
  output logic [31:0]              pa_o,
  output logic [31:0]              pb_o,
  output logic [31:0]              mck_o,
  output logic [NUM_PCK-1:0][31:0] pck_o
);
  import clkctl_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_o <= '0;
      pa_o  <= PLL_RST;
      pb_o  <= PLL_RST;
      mck_o <= '0;
    end else begin
      if (osc_wr_i) osc_o <= wdata_i;
      if (pa_wr_i)  pa_o  <= wdata_i;
      if (pb_wr_i)  pb_o  <= wdata_i;
      if (mck_wr_i) mck_o <= wdata_i;
    end
  end

  for (genvar i = 0; i < NUM_PCK; i++) begin : g_pck
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          pck_o[i] <= '0;
      else if (pck_wr_i[i]) pck_o[i] <= wdata_i;
    end
  end

  AST_PCK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pck_wr_i)) else $error("pck decode overlap"); // R1
endmodule

// File: rtl/clkctl_status.sv
module clkctl_status (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        osc_wr_i,
  input  logic        pa_wr_i,
  input  logic        pb_wr_i,
  input  logic        mck_ready_i,
  input  logic [31:0] mask_i,
  output logic [31:0] stat_o,
  output logic        irq_o
);
  import clkctl_pkg::*;

  logic [NUM_FLAGS-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= NUM_FLAGS'(1) << FL_MCK;
    end else begin
      if (osc_wr_i) flags_q[FL_OSC]    <= 1'b1;
      if (pa_wr_i)  flags_q[FL_LOCK_A] <= 1'b1;
      if (pb_wr_i)  flags_q[FL_LOCK_B] <= 1'b1;
      flags_q[FL_MCK] <= mck_ready_i;
    end
  end

  assign stat_o = 32'(flags_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_o & mask_i);
  end

  AST_OSC_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_wr_i |=> stat_o[FL_OSC]) else $error("osc flag"); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(stat_o[FL_LOCK_A]) && !$fell(stat_o[FL_LOCK_B]) && !$fell(stat_o[FL_OSC]))
    else $error("lock flag dropped"); // R4
  AST_MCK_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (stat_o[FL_MCK] == $past(mck_ready_i))) else $error("mck flag"); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> !irq_o) else $error("irq with empty mask"); // R7
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs #(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned NUM_PCK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [31:0]       osc_freq_i,
  input  logic              mck_ready_i,
  output logic              irq_o
);
  import clkctl_pkg::*;

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic [31:0] sys_q, per_q, mask_q, stat_q;
  logic [31:0] osc_q, pa_q, pb_q, mck_q;
  logic [NUM_PCK-1:0][31:0] pck_q;
  logic [NUM_PCK-1:0] pck_wr;
  logic osc_wr, pa_wr, pb_wr, mck_wr;

  assign osc_wr = we_i && hit(addr_i, OFF_OSC);
  assign pa_wr  = we_i && hit(addr_i, OFF_PLL_A);
  assign pb_wr  = we_i && hit(addr_i, OFF_PLL_B);
  assign mck_wr = we_i && hit(addr_i, OFF_MCK);
  for (genvar i = 0; i < NUM_PCK; i++) begin : g_pck_dec
    assign pck_wr[i] = we_i && hit(addr_i, 8'(OFF_PCK0 + 4 * i));
  end

  clkctl_setclr #(.W(32), .MASK(SYS_MASK), .RST_VAL(SYS_RST)) u_sys (
    .clk_i, .rst_ni,
    .set_i (we_i && hit(addr_i, OFF_SYS_EN)),
    .clr_i (we_i && hit(addr_i, OFF_SYS_DIS)),
    .wdata_i, .q_o(sys_q));

  clkctl_setclr #(.W(32), .MASK(PER_MASK), .RST_VAL('0)) u_per (
    .clk_i, .rst_ni,
    .set_i (we_i && hit(addr_i, OFF_PER_EN)),
    .clr_i (we_i && hit(addr_i, OFF_PER_DIS)),
    .wdata_i, .q_o(per_q));

  clkctl_setclr #(.W(32), .MASK('1), .RST_VAL('0)) u_mask (
    .clk_i, .rst_ni,
    .set_i (we_i && hit(addr_i, OFF_IEN)),
    .clr_i (we_i && hit(addr_i, OFF_IDIS)),
    .wdata_i, .q_o(mask_q));

  clkctl_cfg #(.NUM_PCK(NUM_PCK)) u_cfg (
    .clk_i, .rst_ni,
    .osc_wr_i(osc_wr), .pa_wr_i(pa_wr), .pb_wr_i(pb_wr), .mck_wr_i(mck_wr),
    .pck_wr_i(pck_wr), .wdata_i,
    .osc_o(osc_q), .pa_o(pa_q), .pb_o(pb_q), .mck_o(mck_q), .pck_o(pck_q));

  clkctl_status u_stat (
    .clk_i, .rst_ni,
    .osc_wr_i(osc_wr), .pa_wr_i(pa_wr), .pb_wr_i(pb_wr),
    .mck_ready_i, .mask_i(mask_q),
    .stat_o(stat_q), .irq_o);

  logic [31:0] fmeas;
  assign fmeas = osc_q[0] ? ((32'd1 << FMEAS_VALID) | (osc_freq_i >> FMEAS_SHIFT)) : '0;

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, OFF_SYS_ST)) rdata_o = sys_q;
    if (hit(addr_i, OFF_PER_ST)) rdata_o = per_q;
    if (hit(addr_i, OFF_OSC))    rdata_o = osc_q;
    if (hit(addr_i, OFF_FMEAS))  rdata_o = fmeas;
    if (hit(addr_i, OFF_PLL_A))  rdata_o = pa_q;
    if (hit(addr_i, OFF_PLL_B))  rdata_o = pb_q;
    if (hit(addr_i, OFF_MCK))    rdata_o = mck_q;
    if (hit(addr_i, OFF_STAT))   rdata_o = stat_q;
    if (hit(addr_i, OFF_MASK))   rdata_o = mask_q;
    for (int i = 0; i < NUM_PCK; i++)
      if (hit(addr_i, 8'(OFF_PCK0 + 4 * i))) rdata_o = pck_q[i];
  end

  always_comb begin
    if (rst_ni && (hit(addr_i, OFF_SYS_EN) || hit(addr_i, OFF_SYS_DIS) ||
        hit(addr_i, OFF_PER_EN) || hit(addr_i, OFF_PER_DIS) ||
        hit(addr_i, OFF_IEN) || hit(addr_i, OFF_IDIS)))
      AST_WO_READ_ZERO: assert (rdata_o == '0) else $error("write-only reads nonzero"); // R9
  end

  AST_PER_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q[1:0] == 2'b00) else $error("per low bits set"); // R3
  AST_FMEAS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit(addr_i, OFF_FMEAS) && !osc_q[0]) |-> (rdata_o == '0)) else $error("fmeas"); // R8
endmodule

// File: tb/clkctl_regs_test.sv
`timescale 1ns/1ps
module clkctl_regs_test;
  localparam logic [31:0] OSC_HZ = 32'd18_432_000;

  logic clk = 0, rst_n = 0, we = 0, mck_rdy = 1;
  logic [6:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  clkctl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .osc_freq_i(OSC_HZ), .mck_ready_i(mck_rdy), .irq_o(irq));

  logic [31:0] m_sys, m_per, m_osc, m_pa, m_pb, m_mck, m_st, m_mask;
  logic [31:0] m_pck [4];

  task automatic model_reset();
    m_sys = 1; m_per = 0; m_osc = 0; m_pa = 32'h3F00; m_pb = 32'h3F00;
    m_mck = 0; m_st = 32'h8; m_mask = 0;
    for (int i = 0; i < 4; i++) m_pck[i] = 0;
  endtask

  function automatic logic [31:0] exp_rd(logic [6:0] a);
    case (a)
      7'h08: return m_sys;
      7'h18: return m_per;
      7'h20: return m_osc;
      7'h24: return m_osc[0] ? (32'h1_0000 | ((OSC_HZ / 32768) / 16)) : 32'h0;
      7'h28: return m_pa;
      7'h2C: return m_pb;
      7'h30: return m_mck;
      7'h40: return m_pck[0];
      7'h44: return m_pck[1];
      7'h48: return m_pck[2];
      7'h4C: return m_pck[3];
      7'h68: return m_st;
      7'h6C: return m_mask;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(logic [6:0] a, logic [31:0] d);
    case (a)
      7'h00: m_sys |= d & 32'hF80;
      7'h04: m_sys &= ~(d & 32'hF80);
      7'h10: m_per |= d & ~32'h3;
      7'h14: m_per &= ~(d & ~32'h3);
      7'h20: begin m_osc = d; m_st |= 1; end
      7'h28: begin m_pa = d; m_st |= 2; end
      7'h2C: begin m_pb = d; m_st |= 4; end
      7'h30: m_mck = d;
      7'h40: m_pck[0] = d;
      7'h44: m_pck[1] = d;
      7'h48: m_pck[2] = d;
      7'h4C: m_pck[3] = d;
      7'h60: m_mask |= d;
      7'h64: m_mask &= ~d;
      default: ;
    endcase
    m_st[3] = mck_rdy;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // write; returns at the negedge after the register update
  task automatic wr(logic [6:0] a, logic [31:0] d, logic rdy);
    @(negedge clk);
    addr = a; wdata = d; we = 1; mck_rdy = rdy;
    @(negedge clk);
    we = 0;
    model_wr(a, d);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rd_chk(logic [6:0] a, string req);
    addr = a; #0.5;
    chk(req, rdata, exp_rd(a));
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < 32; k++) rd_chk(7'(k * 4), req);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C10C));
    model_reset();
    #9 rst_n = 1;
    idle();
    // R10 reset values, R9 write-only/unmapped read 0
    check_all("R10");
    chk("R10 irq", 32'(irq), 0);

    // R2: disable all ones leaves bit 0; enable sets only 11:7
    wr(7'h04, 32'hFFFF_FFFF, 1); rd_chk(7'h08, "R2");
    wr(7'h00, 32'hFFFF_FFFF, 1); rd_chk(7'h08, "R2");
    chk("R2 value", rdata, 32'hF81);
    wr(7'h04, 32'h0000_0100, 1); rd_chk(7'h08, "R2");

    // R3: bits 1:0 never set
    wr(7'h10, 32'hFFFF_FFFF, 1); chk("R3", exp_rd(7'h18), 32'hFFFF_FFFC); rd_chk(7'h18, "R3");
    wr(7'h14, 32'h0000_F00F, 1); rd_chk(7'h18, "R3");

    // R8: measure gated by osc bit 0
    wr(7'h20, 32'h0000_FF00, 1); rd_chk(7'h24, "R8");
    chk("R8 off", rdata, 0);
    wr(7'h20, 32'h0000_0001, 1); rd_chk(7'h24, "R8");
    chk("R8 on", rdata, 32'h1_0000 | 32'd35);
    rd_chk(7'h68, "R4");

    // R7: irq registered, one cycle after mask write
    wr(7'h60, 32'h0000_0002, 1);
    chk("R7 latency", 32'(irq), 0);
    rd_chk(7'h6C, "R6");
    idle();
    chk("R7 still 0 lock A clear", 32'(irq), 0);
    wr(7'h28, 32'h1234_5678, 1);
    chk("R7 latency", 32'(irq), 0);
    idle();
    chk("R7", 32'(irq), 1);
    // R5: mck ready follows input, drives irq through mask bit 3
    wr(7'h64, 32'hFFFF_FFFF, 1); idle();
    chk("R6 cleared irq", 32'(irq), 0);
    wr(7'h60, 32'h8, 0); rd_chk(7'h68, "R5");
    idle(); chk("R5 irq", 32'(irq), 0);
    wr(7'h6C, 32'h0, 1); rd_chk(7'h68, "R5"); rd_chk(7'h6C, "R9");
    idle(); chk("R5 irq", 32'(irq), 1);

    // random mix, including read-only and unmapped offsets (R1, R4, R6, R9)
    for (int it = 0; it < 300; it++) begin
      logic [6:0] a;
      logic [31:0] d;
      a = 7'($urandom_range(0, 31) * 4);
      d = $urandom();
      wr(a, d, 1'($urandom_range(0, 1)));
      check_all("R1");
      idle();
      chk("R7 random", 32'(irq), 32'(|(m_st & m_mask)));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule